// File: doc/BRIEF.md
# Bus Master Request Control and Status Register

This block is the 32-bit control and status word of a bus-master bridge that moves data through two FIFOs, one for each direction. The host reads and writes the word through a plain register port. The read data is assembled combinationally from two sources. The first is live fill levels of the two FIFOs and two transfer counters. The second is the control bits the block stores. The block holds per-direction enable, threshold-scheme and priority bits. From these it decides which direction raises a bus-master request.

A "write" transfer drains the add-on-to-host FIFO toward host memory. A "read" transfer fills the host-to-add-on FIFO from host memory. A request is held until the bus engine pulses `grant_done`. The block then waits one idle cycle and evaluates eligibility again. Three flag-clear bits produce single-cycle strobes. A fourth bit drives a held reset level toward the add-on side. After reset, with empty FIFOs and zero counters, the word reads 000000E6h.

Top module: `bm_ctlstat`

## Requirements
- R1: After reset, with both FIFO levels 0 and both transfer counts 0, the register reads 000000E6h. Both requests, all strobes, `addon_rst` and `mrm_en` are 0.
- R2: The read-only FIFO status bits are as follows. Bit 0: host-to-add-on level equals DEPTH. Bit 1: host-to-add-on free space (DEPTH minus level) is at least THRESH. Bit 2: host-to-add-on level is 0. Bit 3: add-on-to-host level equals DEPTH. Bit 4: add-on-to-host level is at least THRESH. Bit 5: add-on-to-host level is 0.
- R3: Bit 6 reads 1 when `h2a_tcount` is 0. Bit 7 reads 1 when `a2h_tcount` is 0.
- R4: The stored control bits read back as written. Bit 8 is write priority, bit 9 is write scheme, bit 10 is write enable, bit 12 is read priority, bit 13 is read scheme, bit 14 is read enable, bit 15 is memory-read-multiple enable and bit 24 is add-on reset. Bits 11, 16–23 and 25–31 read 0, and writes to bits 0–7 have no effect.
- R5: A write of 1 to bit 25, 26 or 27 pulses `h2a_flag_rst`, `a2h_flag_rst` or `mbox_flag_rst`, in that order, for exactly the one cycle after the write edge.
- R6: `addon_rst` follows stored bit 24. It changes only through a register write.
- R7: The write direction is eligible when bit 10 is set, `a2h_tcount` is nonzero and the add-on-to-host level is at least 1. When bit 9 is set, the level must instead be at least THRESH.
- R8: The read direction is eligible when bit 14 is set, `h2a_tcount` is nonzero and the host-to-add-on free space is at least 1. When bit 13 is set, the free space must instead be at least THRESH.
- R9: When both directions are eligible in an idle cycle, a direction whose priority bit is the only one set wins.
- R10: When both directions are eligible and the two priority bits are equal, the grant goes to the direction opposite the last one granted. The first such grant after reset goes to write.
- R11: A request rises the cycle after eligibility is seen while idle. It stays high until `grant_done` is sampled high, then falls for one cycle. The two requests are never high together.
- R12: Only `reg_addr` equal to CSR_OFFSET (3Ch) selects the register. At any other address, writes are ignored and `reg_rdata` is 0.
- R13: `mrm_en` follows stored bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| h2a_level | input | LW | Host-to-add-on FIFO fill level |
| a2h_level | input | LW | Add-on-to-host FIFO fill level |
| h2a_tcount | input | TCW | Host-to-add-on transfer count |
| a2h_tcount | input | TCW | Add-on-to-host transfer count |
| grant_done | input | 1 | Pulse ending the current request |
| wr_req | output | 1 | Write-direction master request |
| rd_req | output | 1 | Read-direction master request |
| mrm_en | output | 1 | Memory-read-multiple enable |
| addon_rst | output | 1 | Held add-on reset level |
| h2a_flag_rst | output | 1 | One-cycle host-to-add-on flag clear |
| a2h_flag_rst | output | 1 | One-cycle add-on-to-host flag clear |
| mbox_flag_rst | output | 1 | One-cycle mailbox flag clear |

## Verification
Directed sequences step the add-on-to-host level across the threshold with the scheme bit set. This separates the at-least-one rule from the at-least-four rule. They also pulse and withhold `grant_done` to expose the hold and the one-cycle gap. Random cycles mix FIFO levels from empty to full, transfer counts biased toward zero, occasional writes at random addresses and random `grant_done`. These cycles reach ties with equal and unequal priority bits, which separates priority wins from alternation. They also reach stray-address writes and read-only bits written with ones.

// File: rtl/bm_ctlstat.sv
module bm_ctlstat #(
  parameter int DEPTH = 8,
  parameter int THRESH = 4,
  parameter int TCW = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] CSR_OFFSET = 8'h3C,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic [LW-1:0]  h2a_level,
  input  logic [LW-1:0]  a2h_level,
  input  logic [TCW-1:0] h2a_tcount,
  input  logic [TCW-1:0] a2h_tcount,
  input  logic           grant_done,
  output logic           wr_req,
  output logic           rd_req,
  output logic           mrm_en,
  output logic           addon_rst,
  output logic           h2a_flag_rst,
  output logic           a2h_flag_rst,
  output logic           mbox_flag_rst
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] THR  = LW'(THRESH);

  logic wr_pri, wr_sch, wr_en, rd_pri, rd_sch, rd_en;
  logic last_rd;
  logic hit, wr_hit;
  logic [LW-1:0] h2a_space;
  logic wr_elig, rd_elig, pick_wr;
  logic [7:0] status;

  assign hit       = reg_addr == CSR_OFFSET;
  assign wr_hit    = reg_wr && hit;
  assign h2a_space = FULL - h2a_level;

  assign status = {a2h_tcount == '0, h2a_tcount == '0,
                   a2h_level == '0, a2h_level >= THR, a2h_level == FULL,
                   h2a_level == '0, h2a_space >= THR, h2a_level == FULL};

  assign reg_rdata = hit ? {7'd0, addon_rst, 8'd0, mrm_en, rd_en, rd_sch, rd_pri,
                            1'b0, wr_en, wr_sch, wr_pri, status} : 32'd0;

  assign wr_elig = wr_en && (a2h_tcount != '0) &&
                   (wr_sch ? (a2h_level >= THR) : (a2h_level != '0));
  assign rd_elig = rd_en && (h2a_tcount != '0) &&
                   (rd_sch ? (h2a_space >= THR) : (h2a_space != '0));

  assign pick_wr = wr_elig && (!rd_elig || (wr_pri && !rd_pri) ||
                               ((wr_pri == rd_pri) && last_rd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {wr_pri, wr_sch, wr_en, rd_pri, rd_sch, rd_en} <= '0;
      mrm_en    <= 1'b0;
      addon_rst <= 1'b0;
      {mbox_flag_rst, a2h_flag_rst, h2a_flag_rst} <= '0;
    end else begin
      {mbox_flag_rst, a2h_flag_rst, h2a_flag_rst} <= wr_hit ? reg_wdata[27:25] : 3'd0;
      if (wr_hit) begin
        {wr_en, wr_sch, wr_pri} <= reg_wdata[10:8];
        {mrm_en, rd_en, rd_sch, rd_pri} <= reg_wdata[15:12];
        addon_rst <= reg_wdata[24];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      last_rd <= 1'b1;
    end else if (wr_req || rd_req) begin
      if (grant_done) begin
        wr_req <= 1'b0;
        rd_req <= 1'b0;
      end
    end else if (wr_elig || rd_elig) begin
      wr_req  <= pick_wr;
      rd_req  <= !pick_wr;
      last_rd <= !pick_wr;
    end
  end
endmodule

module bm_ctlstat_chk #(
  parameter int TCW = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] CSR_OFFSET = 8'h3C
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [31:0]    reg_wdata,
  input logic [31:0]    reg_rdata,
  input logic [TCW-1:0] h2a_tcount,
  input logic [TCW-1:0] a2h_tcount,
  input logic           grant_done,
  input logic           wr_req,
  input logic           rd_req,
  input logic           addon_rst,
  input logic           h2a_flag_rst,
  input logic           a2h_flag_rst,
  input logic           mbox_flag_rst
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_req && rd_req)); // R11
  AST_WR_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) wr_req && !grant_done |=> wr_req); // R11
  AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rd_req && !grant_done |=> rd_req); // R11
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (wr_req || rd_req) && grant_done |=> !wr_req && !rd_req); // R11
  AST_WR_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_req) |-> $past(a2h_tcount != '0)); // R7
  AST_RD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_req) |-> $past(h2a_tcount != '0)); // R8
  AST_H2A_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) h2a_flag_rst |-> $past(reg_wr && reg_addr == CSR_OFFSET && reg_wdata[25])); // R5
  AST_A2H_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) a2h_flag_rst |-> $past(reg_wr && reg_addr == CSR_OFFSET && reg_wdata[26])); // R5
  AST_MBOX_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) mbox_flag_rst |-> $past(reg_wr && reg_addr == CSR_OFFSET && reg_wdata[27])); // R5
  AST_ADDON_RST_STEADY: assert property (@(posedge clk) disable iff (!rst_n) !$stable(addon_rst) |-> $past(reg_wr && reg_addr == CSR_OFFSET)); // R6
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[31:25] == '0 && reg_rdata[23:16] == '0 && !reg_rdata[11]); // R4
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_addr != CSR_OFFSET |-> reg_rdata == '0); // R12
endmodule

bind bm_ctlstat bm_ctlstat_chk #(.TCW(TCW), .AW(AW), .CSR_OFFSET(CSR_OFFSET)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .h2a_tcount(h2a_tcount), .a2h_tcount(a2h_tcount),
  .grant_done(grant_done), .wr_req(wr_req), .rd_req(rd_req), .addon_rst(addon_rst),
  .h2a_flag_rst(h2a_flag_rst), .a2h_flag_rst(a2h_flag_rst), .mbox_flag_rst(mbox_flag_rst)
);

// File: tb/test_bm_ctlstat.sv
module test_bm_ctlstat;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4;
  localparam logic [31:0] CTRL_MASK = 32'h0100_F700;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h3C;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [LW-1:0] h2a_level = '0, a2h_level = '0;
  logic [15:0] h2a_tcount = '0, a2h_tcount = '0;
  logic grant_done = 1'b0;
  logic wr_req, rd_req, mrm_en, addon_rst, h2a_flag_rst, a2h_flag_rst, mbox_flag_rst;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_ctrl = '0;
  logic [2:0] m_strb = '0;
  logic m_wq = 1'b0, m_rq = 1'b0, m_last_rd = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_ctlstat i_bm_ctlstat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .h2a_level(h2a_level), .a2h_level(a2h_level),
    .h2a_tcount(h2a_tcount), .a2h_tcount(a2h_tcount), .grant_done(grant_done),
    .wr_req(wr_req), .rd_req(rd_req), .mrm_en(mrm_en), .addon_rst(addon_rst),
    .h2a_flag_rst(h2a_flag_rst), .a2h_flag_rst(a2h_flag_rst), .mbox_flag_rst(mbox_flag_rst)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] a, int hl, int al, int ht, int at,
                                         logic [31:0] c);
    logic [31:0] r;
    r = c & CTRL_MASK;
    r[0] = (hl == 8);
    r[1] = ((8 - hl) >= 4);
    r[2] = (hl == 0);
    r[3] = (al == 8);
    r[4] = (al >= 4);
    r[5] = (al == 0);
    r[6] = (ht == 0);
    r[7] = (at == 0);
    return (a == 8'h3C) ? r : 32'd0;
  endfunction

  task automatic model_edge();
    logic we, re, pw;
    int hl, al;
    hl = int'(h2a_level);
    al = int'(a2h_level);
    if (m_wq || m_rq) begin
      if (grant_done) begin
        m_wq = 1'b0;
        m_rq = 1'b0;
      end
    end else begin
      we = m_ctrl[10] && (a2h_tcount != 0) && (m_ctrl[9] ? (al >= 4) : (al >= 1));
      re = m_ctrl[14] && (h2a_tcount != 0) && (m_ctrl[13] ? ((8 - hl) >= 4) : ((8 - hl) >= 1));
      if (we || re) begin
        pw = we && (!re || (m_ctrl[8] && !m_ctrl[12]) || ((m_ctrl[8] == m_ctrl[12]) && m_last_rd));
        m_wq = pw;
        m_rq = !pw;
        m_last_rd = !pw;
      end
    end
    if (reg_wr && reg_addr == 8'h3C) begin
      m_ctrl = reg_wdata & CTRL_MASK;
      m_strb = reg_wdata[27:25];
    end else begin
      m_strb = '0;
    end
  endtask

  task automatic check_outputs();
    chk({wr_req, rd_req} === {m_wq, m_rq}, "R7 R8 R9 R10 R11 requests",
        {30'd0, wr_req, rd_req}, {30'd0, m_wq, m_rq});
    chk({mbox_flag_rst, a2h_flag_rst, h2a_flag_rst} === m_strb, "R5 strobes",
        {29'd0, mbox_flag_rst, a2h_flag_rst, h2a_flag_rst}, {29'd0, m_strb});
    chk(addon_rst === m_ctrl[24], "R6 addon reset", {31'd0, addon_rst}, {31'd0, m_ctrl[24]});
    chk(mrm_en === m_ctrl[15], "R13 mrm enable", {31'd0, mrm_en}, {31'd0, m_ctrl[15]});
    chk(reg_rdata === exp_rd(reg_addr, int'(h2a_level), int'(a2h_level), int'(h2a_tcount),
                             int'(a2h_tcount), m_ctrl),
        "R2 R3 R4 R12 readback", reg_rdata,
        exp_rd(reg_addr, int'(h2a_level), int'(a2h_level), int'(h2a_tcount), int'(a2h_tcount), m_ctrl));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic wr_csr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    tick();
    reg_wr = 1'b0;
    reg_addr = 8'h3C;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reg_rdata === 32'h0000_00E6, "R1 reset readback", reg_rdata, 32'h0000_00E6);
    chk({wr_req, rd_req, mrm_en, addon_rst, h2a_flag_rst, a2h_flag_rst, mbox_flag_rst} === 7'd0,
        "R1 reset outputs",
        {25'd0, wr_req, rd_req, mrm_en, addon_rst, h2a_flag_rst, a2h_flag_rst, mbox_flag_rst}, 32'd0);

    // R7 threshold scheme: 3 words no request, 4 words request
    a2h_level = 4'd3;
    a2h_tcount = 16'd5;
    wr_csr(8'h3C, 32'h0000_0600);
    tick();
    chk(wr_req === 1'b0, "R7 below threshold", {31'd0, wr_req}, 32'd0);
    a2h_level = 4'd4;
    tick();
    chk(wr_req === 1'b1, "R7 at threshold", {31'd0, wr_req}, 32'd1);
    grant_done = 1'b1;
    tick();
    chk(wr_req === 1'b0, "R11 drop after done", {31'd0, wr_req}, 32'd0);
    grant_done = 1'b0;
    tick();
    chk(wr_req === 1'b1, "R11 re-request", {31'd0, wr_req}, 32'd1);
    grant_done = 1'b1;
    tick();

    // R10 tie alternation, R9 priority, both directions eligible
    h2a_level = 4'd0;
    h2a_tcount = 16'd7;
    wr_csr(8'h3C, 32'h0000_4400);
    repeat (8) tick();
    wr_csr(8'h3C, 32'h0000_4500);
    repeat (6) tick();
    wr_csr(8'h3C, 32'h0000_5400);
    repeat (6) tick();
    wr_csr(8'h3C, 32'h0000_5500);
    repeat (6) tick();
    grant_done = 1'b0;

    // R5 strobes, R6 held reset, R12 stray address, R4 read-only bits
    wr_csr(8'h3C, 32'h0F00_80FF);
    chk({mbox_flag_rst, a2h_flag_rst, h2a_flag_rst} === 3'b111, "R5 strobe pulse",
        {29'd0, mbox_flag_rst, a2h_flag_rst, h2a_flag_rst}, 32'd7);
    tick();
    chk(addon_rst === 1'b1, "R6 held level", {31'd0, addon_rst}, 32'd1);
    wr_csr(8'h38, 32'h0000_0000);
    chk(addon_rst === 1'b1, "R12 stray write ignored", {31'd0, addon_rst}, 32'd1);
    reg_addr = 8'h38;
    tick();
    reg_addr = 8'h3C;
    grant_done = 1'b1;
    wr_csr(8'h3C, 32'h0000_0000);
    tick();

    for (int i = 0; i < 4000; i++) begin
      reg_wr = ($urandom % 6) == 0;
      reg_addr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h3C;
      reg_wdata = $urandom;
      h2a_level = LW'($urandom % 9);
      a2h_level = LW'($urandom % 9);
      h2a_tcount = (($urandom % 4) == 0) ? 16'd0 : 16'($urandom % 16);
      a2h_tcount = (($urandom % 4) == 0) ? 16'd0 : 16'($urandom % 16);
      grant_done = ($urandom % 3) == 0;
      tick();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule